// File: doc/BRIEF.md
# Latency-Modeling Sequential-Burst Memory

This block is a byte-wide read-only store that reproduces the timing of a slower device. Every accepted read is answered after a delay that depends on where the address lies relative to the previous accepted read. If the new address is exactly one above the previous one, the read continues a stream and pays only the short streaming interval. Any other address pays the full first-access latency. Each location holds a byte computed from its own address, so the contents are known without a load phase.

Both delays are parameters, so one design can stand for a fast register file (1/1), a main-memory store (10/2) or a disk-like store (100/24). A 32-bit counter adds up every delay charged. A test can then compare a whole run with the closed form: a burst of n consecutive bytes costs one access latency plus n-1 stream intervals. Only one read is in flight at a time. A request made while a read is pending is dropped.

Top module: `burst_latency_mem`

## Requirements
- R1: While reset (rst_n low) is applied and directly after it, rvalid and busy are 0 and total_delay is 0.
- R2: A read is accepted on a rising clock edge where req is 1 and busy is 0. If its address is not one above the previously accepted address, rvalid rises exactly FIRST_LAT rising edges after the accepting edge.
- R3: If an accepted address equals the previously accepted address plus one, rvalid rises exactly STREAM_LAT edges after the accepting edge.
- R4: The first read after reset is non-sequential. A read at address 0 after a read at the top address is also non-sequential, because the address does not wrap into a run.
- R5: When rvalid is 1, rdata equals (addr[7:0] XOR (addr >> 8) XOR 8'hA5) truncated to DATA_W bits, using the address of the completing read. With wider addresses, further 8-bit slices are XORed in.
- R6: A request made while busy is 1 is ignored. It changes neither total_delay, nor the timing or data of the pending response, nor the address that the next read is compared against.
- R7: On each accepted read, total_delay increases by the delay charged to that read, and it is unchanged otherwise. A run of n consecutive addresses starting with a non-sequential read adds FIRST_LAT + (n-1)*STREAM_LAT.
- R8: rvalid is a single-cycle pulse. busy is 1 from the cycle after the accepting edge until rvalid rises, and busy and rvalid are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request, sampled when busy is 0 |
| addr | input | ADDR_W | Byte address of the request |
| rvalid | output | 1 | One-cycle pulse marking rdata valid |
| rdata | output | DATA_W | Returned byte |
| busy | output | 1 | A read is pending; requests are dropped |
| total_delay | output | CNT_W | Running sum of all delays charged |

## Verification
The bound checker watches on every cycle:
- the delay selected for each accepted read against the sequential test;
- the cycles between acceptance and rvalid, counted against that delay;
- the step and hold rules of the delay total;
- the pulse shape of rvalid and its exclusion with busy;
- that no request is accepted while busy.

The checker cannot decide whether an address was sequential independently of the design. Only the bench, with its own model of the last accepted address, can show that:
- the first read after reset and the wrap from the top address pay full latency;
- ignored requests leave the run tracking untouched;
- the returned bytes match the address pattern;
- burst totals match the closed form.

// File: rtl/blm_pkg.sv
package blm_pkg;

  // Fold an address into a data-width byte pattern: XOR of all
  // data-width slices of the address, then XOR with a seed.
  function automatic logic [31:0] fold_pattern(input logic [31:0] a,
                                               input int aw,
                                               input int dw,
                                               input logic [31:0] seed);
    logic [31:0] acc;
    acc = seed;
    for (int s = 0; s < aw; s += dw) begin
      acc = acc ^ (a >> s);
    end
    return acc;
  endfunction

  // True when addr continues a run from prev; no wrap at the top.
  function automatic logic next_in_run(input logic [31:0] prev,
                                       input logic have_prev,
                                       input logic [31:0] addr);
    logic [32:0] succ;
    succ = {1'b0, prev} + 33'd1;
    return have_prev && (succ == {1'b0, addr});
  endfunction

  // Delay charged for a read given its run status.
  function automatic int charge_for(input logic seq,
                                    input int first_lat,
                                    input int stream_lat);
    return seq ? stream_lat : first_lat;
  endfunction

endpackage

// File: rtl/blm_seq_track.sv
module blm_seq_track #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_seq
);
  import blm_pkg::*;

  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;

  always_comb begin
    is_seq = next_in_run(32'(prev_addr), have_prev, 32'(addr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (accept) begin
      prev_addr <= addr;
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/blm_delay_timer.sv
module blm_delay_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LAT_W-1:0] load_val,
  output logic             busy,
  output logic             finish,
  output logic             done
);
  logic [LAT_W-1:0] remain;

  // finish marks the edge on which the response is produced
  always_comb begin
    finish = busy && (remain == LAT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        remain <= load_val;
        busy   <= 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        remain <= remain - LAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/blm_delay_total.sv
module blm_delay_total #(
  parameter int LAT_W = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LAT_W-1:0] charge,
  output logic [CNT_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total <= '0;
    end else if (accept) begin
      total <= total + CNT_W'(charge);
    end
  end
endmodule

// File: rtl/burst_latency_mem.sv
module burst_latency_mem #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int FIRST_LAT  = 10,
  parameter int STREAM_LAT = 2,
  parameter int CNT_W      = 32,
  parameter int PAT_SEED   = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic [CNT_W-1:0]  total_delay
);
  import blm_pkg::*;

  localparam int MAX_LAT = (FIRST_LAT > STREAM_LAT) ? FIRST_LAT : STREAM_LAT;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic              accept;
  logic              is_seq;
  logic [LAT_W-1:0]  charge;
  logic              finish;
  logic [ADDR_W-1:0] held_addr;

  always_comb begin
    accept = req && !busy;
    charge = LAT_W'(charge_for(is_seq, FIRST_LAT, STREAM_LAT));
  end

  blm_seq_track #(.ADDR_W(ADDR_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .addr   (addr),
    .is_seq (is_seq)
  );

  blm_delay_timer #(.LAT_W(LAT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .load_val (charge),
    .busy     (busy),
    .finish   (finish),
    .done     (rvalid)
  );

  blm_delay_total #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_total (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .charge (charge),
    .total  (total_delay)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_addr <= '0;
      rdata     <= '0;
    end else begin
      if (accept) held_addr <= addr;
      if (finish) rdata <= DATA_W'(fold_pattern(32'(held_addr), ADDR_W, DATA_W,
                                                32'(PAT_SEED)));
    end
  end
endmodule

// File: rtl/blm_checker.sv
module blm_checker #(
  parameter int FIRST_LAT  = 10,
  parameter int STREAM_LAT = 2,
  parameter int LAT_W      = 4,
  parameter int CNT_W      = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             accept,
  input logic             is_seq,
  input logic [LAT_W-1:0] charge,
  input logic             busy,
  input logic             rvalid,
  input logic [CNT_W-1:0] total
);
  logic [LAT_W-1:0] wait_cnt;
  logic [LAT_W-1:0] exp_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      exp_lat  <= '0;
    end else if (accept) begin
      wait_cnt <= '0;
      exp_lat  <= charge;
    end else if (busy) begin
      wait_cnt <= wait_cnt + LAT_W'(1);
    end
  end

  a_r2_first_charge: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_seq |-> charge == LAT_W'(FIRST_LAT));
  a_r3_stream_charge: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_seq |-> charge == LAT_W'(STREAM_LAT));
  a_r2_latency_window: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> wait_cnt == exp_lat);
  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req && busy |-> !accept);
  a_r7_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> total == $past(total) + CNT_W'($past(charge)));
  a_r7_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(total));
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rvalid));
endmodule

bind burst_latency_mem blm_checker #(
  .FIRST_LAT  (FIRST_LAT),
  .STREAM_LAT (STREAM_LAT),
  .LAT_W      (LAT_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (req),
  .accept (accept),
  .is_seq (is_seq),
  .charge (charge),
  .busy   (busy),
  .rvalid (rvalid),
  .total  (total_delay)
);

// File: tb/tb_burst_latency_mem.sv
module tb_burst_latency_mem;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int FL = 10;
  localparam int SL = 2;
  localparam int CW = 32;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rvalid;
  logic [DW-1:0] rdata;
  logic          busy;
  logic [CW-1:0] total_delay;

  int     checks = 0;
  int     fails = 0;
  int     prev_a = 0;
  bit     have_prev = 1'b0;
  longint exp_total = 0;

  always #10 clk = ~clk;

  burst_latency_mem #(.ADDR_W(AW), .DATA_W(DW), .FIRST_LAT(FL),
                      .STREAM_LAT(SL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .rvalid(rvalid),
    .rdata(rdata), .busy(busy), .total_delay(total_delay));

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pattern_of(input int a);
    return ((a % 256) ^ (a / 256) ^ 165) % 256;
  endfunction

  function automatic int delay_for(input int a);
    if (have_prev && a == prev_a + 1) return SL;
    return FL;
  endfunction

  // Issue one read from a negedge; returns at a negedge with the bus idle.
  task automatic do_read(input int a, input bit poke, input string tag);
    int exp_l;
    int n;
    string t;
    while (busy) @(negedge clk);
    exp_l = delay_for(a);
    t = (tag != "") ? tag : ((exp_l == SL) ? "R3" : "R2");
    req = 1'b1;
    addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", longint'(busy), 1);
    if (poke) begin
      req = 1'b1;
      addr = AW'($urandom % (TOP + 1));
    end
    n = 1;
    while (!rvalid && n < FL + 5) begin
      @(negedge clk);
      n++;
    end
    req = 1'b0;
    chk(n - 1 == exp_l, {t, " latency"}, n - 1, exp_l);
    chk(int'(rdata) == pattern_of(a), "R5 rdata", int'(rdata), pattern_of(a));
    exp_total += exp_l;
    chk(longint'(total_delay) == exp_total, poke ? "R6 total with dropped req" : "R7 total",
        longint'(total_delay), exp_total);
    have_prev = 1'b1;
    prev_a = a;
    @(negedge clk);
    chk(rvalid == 1'b0, "R8 single pulse", longint'(rvalid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0 && busy == 1'b0, "R1 outputs in reset", longint'({rvalid, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(total_delay == '0, "R1 total after reset", longint'(total_delay), 0);
    chk(busy == 1'b0, "R1 idle after reset", longint'(busy), 0);

    // r4_: first read after reset pays full latency even at address 0's successor
    do_read(1, 1'b0, "R4");

    // R7: burst of 8 starting non-sequential
    base = exp_total;
    do_read(100, 1'b0, "R2");
    for (int i = 1; i < 8; i++) do_read(100 + i, 1'b0, "R3");
    chk(exp_total - base == FL + 7 * SL, "R7 closed form", exp_total - base, FL + 7 * SL);
    chk(longint'(total_delay) - base == FL + 7 * SL, "R7 burst total",
        longint'(total_delay) - base, FL + 7 * SL);

    // R4: no wrap from top address to zero
    do_read(TOP - 1, 1'b0, "R2");
    do_read(TOP, 1'b0, "R3");
    do_read(0, 1'b0, "R4");

    // R6: dropped request during pending read does not break the run
    do_read(500, 1'b1, "R2");
    do_read(501, 1'b1, "R3");
    do_read(502, 1'b0, "R6");

    // repeated same address is non-sequential
    do_read(502, 1'b0, "R2");

    for (int k = 0; k < 400; k++) begin
      int a;
      if ($urandom % 10 < 6) a = (prev_a + 1) % (TOP + 1);
      else a = int'($urandom % (TOP + 1));
      do_read(a, ($urandom % 5) == 0, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule